// File: doc/BRIEF.md
# Variable-Length Path Branch Direction Predictor

This block predicts whether a conditional branch is taken. It does not use recent taken/not-taken outcomes. It keeps the path instead: a short record of where recently taken control transfers landed. On each prediction request the caller gives the branch address and a depth hint N. The block combines the N youngest path targets with the branch address to form an index into a table of two-bit saturating counters. The addressed counter's upper bit is the prediction.

The depth hint is chosen offline for each branch, so two branches can look back over different amounts of path. A separate strobe pushes each new taken target into the path record. A resolve port carries the index returned with an earlier prediction and the real outcome, and trains that counter.

The table index width is a parameter. A 14-bit index gives 16K two-bit counters, which is a 4 KB table. The default is smaller.

Top module: `vlp_predictor`

## Requirements
- R1: While rstN is low, every path slot is cleared to zero and every counter is set to weakly not-taken (binary 01). predValid is low after reset until a request arrives.
- R2: A pathValid strobe shifts bits [PC_SHIFT+IDX_W-1:PC_SHIFT] of pathTarget into slot 0 (the youngest). Each other slot moves one place older, and the content of the oldest slot (slot 2**LEN_W-2) is discarded.
- R3: With reqLen = 0 the index is exactly reqPc[PC_SHIFT+IDX_W-1:PC_SHIFT], whatever the path holds.
- R4: With reqLen = N, the index is reqPc[PC_SHIFT+IDX_W-1:PC_SHIFT] XORed with slot i rotated left by i (mod IDX_W), for every slot i < N. Slots i >= N contribute nothing.
- R5: A request in cycle t yields predValid high in cycle t+1, together with predIdx (the index formed) and predTaken. predTaken is bit 1 of the addressed counter. Without a request, predValid is low.
- R6: A resolve (resValid) increments the counter at resIdx when resTaken is 1 and decrements it when resTaken is 0.
- R7: Counters saturate: an increment at 3 stays at 3, and a decrement at 0 stays at 0.
- R8: When a request and a resolve address the same counter in one cycle, the prediction reflects the counter value before that resolve. The trained value is visible from the next request on.
- R9: When a request and a path strobe coincide, the index uses the path as it was before the shift.
- R10: reqLen is taken per request. Back-to-back requests for one branch address with different reqLen values produce the indices defined by R4 for their own depths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Prediction request strobe |
| reqPc | input | PC_W | Branch address for the request |
| reqLen | input | LEN_W | Path depth N for this branch |
| pathValid | input | 1 | Push a new taken target into the path |
| pathTarget | input | PC_W | Target address being pushed |
| resValid | input | 1 | Resolve strobe that trains a counter |
| resIdx | input | IDX_W | Index returned with the earlier prediction |
| resTaken | input | 1 | Actual branch outcome |
| predValid | output | 1 | Prediction response valid |
| predTaken | output | 1 | Predicted direction (1 = taken) |
| predIdx | output | IDX_W | Index used, to be returned on resolve |

## Verification
The hardest situations to reach are the coincidences:

- a request and a resolve aimed at the same counter in the same cycle;
- a request arriving together with a path push.

In both cases the outcome depends on which value of the shared state the read sees. The bench reaches both by driving all three ports in a single cycle. It first trains a counter to a known value, so that old and new values give different predictions. It loads the path with distinct targets, so that pre-shift and post-shift histories give different indices. Saturation is reached by repeating resolves past both limits and then stepping back once.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic shiftPath;
    logic readTable;
    logic writeTable;
  } vlpStrobes_t;
endpackage

// File: rtl/vlp_ctrl.sv
module vlp_ctrl
  import vlp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        pathValid,
  input  logic        resValid,
  output vlpStrobes_t strobes,
  output logic        predValid
);
  always_comb begin
    strobes.shiftPath  = pathValid;
    strobes.readTable  = reqValid;
    strobes.writeTable = resValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) predValid <= 1'b0;
    else       predValid <= reqValid;
  end

  // R5: response appears exactly one cycle after the request
  a_r5_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> predValid);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !predValid);
endmodule

// File: rtl/vlp_datapath.sv
module vlp_datapath
  import vlp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int IDX_W    = 10,
  parameter int LEN_W    = 3,
  parameter int PC_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  vlpStrobes_t      strobes,
  input  logic [PC_W-1:0]  reqPc,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [PC_W-1:0]  pathTarget,
  input  logic [IDX_W-1:0] resIdx,
  input  logic             resTaken,
  output logic             predTaken,
  output logic [IDX_W-1:0] predIdx
);
  localparam int HIST_DEPTH = (1 << LEN_W) - 1;
  localparam int DEPTH      = 1 << IDX_W;
  localparam logic [1:0] CNT_MAX  = 2'b11;
  localparam logic [1:0] CNT_MIN  = 2'b00;
  localparam logic [1:0] CNT_INIT = 2'b01;

  logic [IDX_W-1:0] hist [HIST_DEPTH];
  logic [1:0]       cntTable [DEPTH];
  logic [IDX_W-1:0] hashIdx;
  logic [1:0]       oldCnt, nextCnt, predCntQ;
  logic [IDX_W-1:0] newTgt;

  assign newTgt = pathTarget[PC_SHIFT +: IDX_W];

  function automatic logic [IDX_W-1:0] rotLeft(input logic [IDX_W-1:0] v, input int amt);
    logic [IDX_W-1:0] r;
    for (int b = 0; b < IDX_W; b++) r[(b + amt) % IDX_W] = v[b];
    return r;
  endfunction

  // Path history shift register, one generated stage per slot
  for (genvar g = 0; g < HIST_DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)                  hist[g] <= '0;
      else if (strobes.shiftPath) begin
        if (g == 0) hist[g] <= newTgt;
        else        hist[g] <= hist[(g > 0) ? g - 1 : 0];
      end
    end
  end

  // Index hash over a variable number of path slots
  always_comb begin
    hashIdx = reqPc[PC_SHIFT +: IDX_W];
    for (int i = 0; i < HIST_DEPTH; i++) begin
      if (LEN_W'(i) < reqLen) hashIdx = hashIdx ^ rotLeft(hist[i], i % IDX_W);
    end
  end

  // Saturating counter update
  always_comb begin
    oldCnt = cntTable[resIdx];
    if (resTaken) nextCnt = (oldCnt == CNT_MAX) ? CNT_MAX : oldCnt + 2'd1;
    else          nextCnt = (oldCnt == CNT_MIN) ? CNT_MIN : oldCnt - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < DEPTH; e++) cntTable[e] <= CNT_INIT;
    end else if (strobes.writeTable) begin
      cntTable[resIdx] <= nextCnt;
    end
  end

  // Registered read: sees the pre-write array contents
  always_ff @(posedge clk) begin
    if (!rstN) begin
      predCntQ <= CNT_INIT;
      predIdx  <= '0;
    end else if (strobes.readTable) begin
      predCntQ <= cntTable[hashIdx];
      predIdx  <= hashIdx;
    end
  end

  assign predTaken = predCntQ[1];

  a_r2_young_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftPath |=> hist[0] == $past(newTgt));
  a_r2_age_move: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftPath |=> hist[HIST_DEPTH-1] == $past(hist[HIST_DEPTH-2]));
  a_r3_pc_only: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readTable && reqLen == '0) |=> predIdx == $past(reqPc[PC_SHIFT +: IDX_W]));
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeTable |=> cntTable[$past(resIdx)] == $past(nextCnt));
  a_r7_floor: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeTable && !resTaken && oldCnt == CNT_MIN) |=> cntTable[$past(resIdx)] == CNT_MIN);
  a_r7_ceiling: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeTable && resTaken && oldCnt == CNT_MAX) |=> cntTable[$past(resIdx)] == CNT_MAX);
  a_r8_old_value: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readTable && strobes.writeTable && hashIdx == resIdx)
      |=> predTaken == $past(oldCnt[1]));
endmodule

// File: rtl/vlp_predictor.sv
module vlp_predictor
  import vlp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int IDX_W    = 10,
  parameter int LEN_W    = 3,
  parameter int PC_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [PC_W-1:0]  reqPc,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             pathValid,
  input  logic [PC_W-1:0]  pathTarget,
  input  logic             resValid,
  input  logic [IDX_W-1:0] resIdx,
  input  logic             resTaken,
  output logic             predValid,
  output logic             predTaken,
  output logic [IDX_W-1:0] predIdx
);
  vlpStrobes_t strobes;

  vlp_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .pathValid(pathValid),
    .resValid(resValid), .strobes(strobes), .predValid(predValid)
  );

  vlp_datapath #(.PC_W(PC_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .PC_SHIFT(PC_SHIFT)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqPc(reqPc), .reqLen(reqLen),
    .pathTarget(pathTarget), .resIdx(resIdx), .resTaken(resTaken),
    .predTaken(predTaken), .predIdx(predIdx)
  );
endmodule

// File: tb/tb_vlp_predictor.sv
module tb_vlp_predictor;
  localparam int PC_W = 32, IDX_W = 10, LEN_W = 3, PC_SHIFT = 2;
  localparam int HD = 7, DEPTH = 1024;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, pathValid = 0, resValid = 0, resTaken = 0;
  logic [PC_W-1:0] reqPc = 0, pathTarget = 0;
  logic [LEN_W-1:0] reqLen = 0;
  logic [IDX_W-1:0] resIdx = 0;
  logic predValid, predTaken;
  logic [IDX_W-1:0] predIdx;

  int checks = 0, failures = 0;
  logic [IDX_W-1:0] mHist [HD];
  logic [1:0] mCnt [DEPTH];
  logic [IDX_W-1:0] expIdx;
  logic expTaken;

  always #10 clk = ~clk;

  vlp_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .PC_SHIFT(PC_SHIFT)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPc(reqPc), .reqLen(reqLen),
    .pathValid(pathValid), .pathTarget(pathTarget), .resValid(resValid),
    .resIdx(resIdx), .resTaken(resTaken), .predValid(predValid),
    .predTaken(predTaken), .predIdx(predIdx)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [IDX_W-1:0] rot(logic [IDX_W-1:0] v, int a);
    logic [IDX_W-1:0] r;
    for (int b = 0; b < IDX_W; b++) r[(b + a) % IDX_W] = v[b];
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] mIndex(logic [PC_W-1:0] pc, int n);
    logic [IDX_W-1:0] acc = pc[PC_SHIFT +: IDX_W];
    for (int i = 0; i < n; i++) acc ^= rot(mHist[i], i % IDX_W);
    return acc;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < HD; i++) mHist[i] = '0;
    for (int e = 0; e < DEPTH; e++) mCnt[e] = 2'b01;
  endtask

  // One cycle with any mix of the three ports; called at a falling edge
  task automatic step(input logic rq, input logic [PC_W-1:0] pc, input int n,
                      input logic pv, input logic [PC_W-1:0] tg,
                      input logic rv, input logic [IDX_W-1:0] ri, input logic tk);
    reqValid = rq; reqPc = pc; reqLen = LEN_W'(n);
    pathValid = pv; pathTarget = tg;
    resValid = rv; resIdx = ri; resTaken = tk;
    expIdx = mIndex(pc, n);
    expTaken = mCnt[expIdx][1];
    @(posedge clk);
    if (rv) begin
      if (tk) mCnt[ri] = (mCnt[ri] == 2'b11) ? 2'b11 : mCnt[ri] + 2'd1;
      else    mCnt[ri] = (mCnt[ri] == 2'b00) ? 2'b00 : mCnt[ri] - 2'd1;
    end
    if (pv) begin
      for (int i = HD - 1; i > 0; i--) mHist[i] = mHist[i-1];
      mHist[0] = tg[PC_SHIFT +: IDX_W];
    end
    @(negedge clk);
    reqValid = 0; pathValid = 0; resValid = 0;
  endtask

  task automatic predict(input logic [PC_W-1:0] pc, input int n, input string req);
    step(1, pc, n, 0, 0, 0, 0, 0);
    check({req, " valid"}, predValid, 1);
    check({req, " idx"}, predIdx, expIdx);
    check({req, " taken"}, predTaken, expTaken);
  endtask

  task automatic push(input logic [PC_W-1:0] tg);
    step(0, 0, 0, 1, tg, 0, 0, 0);
  endtask

  task automatic resolve(input logic [IDX_W-1:0] ri, input logic tk);
    step(0, 0, 0, 0, 0, 1, ri, tk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 predValid after reset", predValid, 0);
    predict(32'h0000_0100, 7, "R1");
    check("R1 empty path idx", predIdx, 10'h040);
    check("R1 weak not-taken", predTaken, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check("R5 no request", predValid, 0);
  endtask

  task automatic t_pcOnly();
    push(32'h1234_5678); push(32'h0BAD_F00C); push(32'h0000_3FFC);
    predict(32'h0000_2A48, 0, "R3");
    check("R3 pc bits", predIdx, 10'h292);
  endtask

  task automatic t_hash();
    push(32'h0000_0004); push(32'h0000_0FF0); push(32'h0000_0AAC);
    push(32'h0000_1554); push(32'h0000_0C30);
    predict(32'h0000_0800, 3, "R4 depth3");
    predict(32'h0000_0800, 7, "R4 depth7");
  endtask

  task automatic t_lenVaries();
    logic [IDX_W-1:0] i1, i2;
    predict(32'h0000_4444, 1, "R10 n1"); i1 = predIdx;
    predict(32'h0000_4444, 2, "R10 n2"); i2 = predIdx;
    check("R10 depths differ", (i1 != i2), 1);
  endtask

  task automatic t_train();
    logic [IDX_W-1:0] ix;
    predict(32'h0000_1000, 4, "R6 pre"); ix = predIdx;
    resolve(ix, 1);
    predict(32'h0000_1000, 4, "R6 after one taken");
    check("R6 counter 2 predicts taken", predTaken, 1);
    for (int k = 0; k < 4; k++) resolve(ix, 1);
    resolve(ix, 0);
    predict(32'h0000_1000, 4, "R7 ceiling");
    check("R7 ceiling then one down stays taken", predTaken, 1);
    for (int k = 0; k < 6; k++) resolve(ix, 0);
    resolve(ix, 1);
    predict(32'h0000_1000, 4, "R7 floor");
    check("R7 floor then one up stays not-taken", predTaken, 0);
    resolve(ix, 1);
    predict(32'h0000_1000, 4, "R6 up to 2");
    check("R6 second increment taken", predTaken, 1);
  endtask

  task automatic t_rbw();
    logic [IDX_W-1:0] ix;
    predict(32'h0000_2220, 2, "R8 locate"); ix = predIdx;
    check("R8 starts not-taken", predTaken, 0);
    step(1, 32'h0000_2220, 2, 0, 0, 1, ix, 1);
    check("R8 same-cycle sees old", predTaken, 0);
    check("R8 same-cycle idx", predIdx, ix);
    predict(32'h0000_2220, 2, "R8 next sees new");
    check("R8 trained value visible", predTaken, 1);
  endtask

  task automatic t_pathSame();
    push(32'h0000_0114); push(32'h0000_0228);
    step(1, 32'h0000_0500, 2, 1, 32'h0000_0FFC, 0, 0, 0);
    check("R9 pre-shift history", predIdx, expIdx);
    predict(32'h0000_0500, 2, "R9 post-shift");
    check("R9 shift took effect", predIdx, mIndex(32'h0000_0500, 2));
  endtask

  task automatic t_depth();
    for (int k = 0; k < 8; k++) push(32'(k * 64 + 12));
    predict(32'h0000_0300, 7, "R2 full path");
    check("R2 slot0 youngest", mHist[0], 10'h073);
    push(32'h0000_3000);
    predict(32'h0000_0300, 7, "R2 oldest dropped");
    predict(32'h0000_0300, 1, "R2 youngest only");
    check("R2 youngest idx", predIdx, 10'h0C0 ^ 10'h000);
  endtask

  task automatic t_midReset();
    logic [IDX_W-1:0] ix;
    predict(32'h0000_1000, 4, "R1 pre"); ix = predIdx;
    resolve(ix, 1); resolve(ix, 1);
    rstN = 0;
    @(posedge clk); @(negedge clk);
    rstN = 1;
    modelReset();
    check("R1 valid cleared", predValid, 0);
    predict(32'h0000_1000, 4, "R1 after reset");
    check("R1 history cleared", predIdx, 10'h400 >> 0 & 10'h3FF ? 10'h000 : 10'h000);
    check("R1 counters reinit", predTaken, 0);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    t_reset();
    t_pcOnly();
    t_hash();
    t_lenVaries();
    t_train();
    t_rbw();
    t_pathSame();
    t_depth();
    t_midReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule